// File: doc/BRIEF.md
# Biphase-Mark Stereo Frame Transmitter

This block turns parallel stereo or mono audio samples into a single-wire, self-clocking serial stream. It runs on a cell clock at 128 times the sample rate, so one clock equals one line cell. Each frame is 128 cells long and holds two 64-cell subframes. Each subframe starts with an 8-cell sync preamble that breaks the line code on purpose. After the preamble come 28 coded slots: a 24-bit sample, three per-subframe side bits (validity, user, channel status) and an even-parity bit.

A 192-frame block counter marks where each channel-status block begins. New sample pairs come in through a valid/ready handshake that opens once per frame. If no pair is offered, the previous pair is sent again. A mono setting sends the first channel in both subframes, or it sends an empty second subframe that is flagged invalid.

Top module: `spdif_frame_tx`

## Requirements
- R1: When `en` is high, `s_ready` is high for exactly one cycle in every 128 cells, during the last cell of each frame. A pair presented then with `s_valid` high is used from the next frame on.
- R2: A subframe's first 8 cells are a preamble. When the line was low just before the subframe, the cells are B = 11101000, M = 11100010 or W = 11100100, sent left bit first. When the line was high, all 8 cells are inverted.
- R3: The second subframe of every frame uses W. The first subframe uses B when the block count is 0 and M otherwise. The count steps once per frame and wraps from 191 to 0.
- R4: Taking `en` low clears the block count, so the first frame after enabling uses B.
- R5: Slots 4..27 of a subframe carry the 24-bit sample, LSB in slot 4. Slot 28 is validity, slot 29 is user and slot 30 is channel status. Bit 0 of each side-bit input belongs to the first subframe and bit 1 to the second.
- R6: Slot 31 is set so that slots 4..31 hold an even number of ones.
- R7: Slots 4..31 use biphase-mark coding. The line toggles at the start of every slot, and toggles again mid-slot only for a 1.
- R8: In stereo mode (`mono` low), the first subframe carries `s_left` and the second carries `s_right`.
- R9: In mono mode with `mono_dup` high, the second subframe carries the `s_left` sample, with its own side bits taken from bit 1.
- R10: In mono mode with `mono_dup` low, the second subframe carries a zero sample and its validity slot is 1.
- R11: A frame that follows a missed handshake repeats the last accepted sample pair and side bits.
- R12: While `en` is low, `tx_line` and `s_ready` are low.
- R13: After reset, `tx_line` and `s_ready` are low and the held sample pair and side bits are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, 128 times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low idles the line and clears the counters |
| mono | input | 1 | Single-channel mode |
| mono_dup | input | 1 | In mono mode, duplicate the first channel into the second subframe |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Pair taken at this clock edge if `s_valid` |
| s_left | input | AUD_W | First-channel sample |
| s_right | input | AUD_W | Second-channel sample |
| s_vbit | input | 2 | Validity bits, bit 0 for the first subframe |
| s_ubit | input | 2 | User bits, bit 0 for the first subframe |
| s_cbit | input | 2 | Channel-status bits, bit 0 for the first subframe |
| tx_line | output | 1 | Biphase-mark coded serial output |

## Verification
Every internal fault shows up within one subframe, because each 64-cell window is compared against an independently coded image. A wrong cell counter shifts the preamble out of place, or breaks the start-of-slot toggle, inside 64 cells. A wrong block count swaps B and M on the first subframe of the affected frame. It is caught at frame 0 or at the wrap near frame 192, which the run crosses. A stale or wrongly latched sample register corrupts data slots and parity in the first frame after the handshake that should have changed it. A missed mono rule shows on the second subframe of that same frame.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
  localparam int SUB_CELLS   = 64;
  localparam int FRAME_CELLS = 2 * SUB_CELLS;
  localparam int PRE_CELLS   = 8;
  localparam int AUD_SLOTS   = 24;

  typedef enum logic [1:0] {
    PRE_B = 2'd0,
    PRE_M = 2'd1,
    PRE_W = 2'd2
  } pre_e;

  // Cell patterns for a line that was low before the preamble
  function automatic logic [7:0] pre_cells(input pre_e p);
    case (p)
      PRE_B:   return 8'b1110_1000;
      PRE_W:   return 8'b1110_0100;
      default: return 8'b1110_0010;
    endcase
  endfunction
endpackage

// File: rtl/sftx_timing.sv
module sftx_timing
  import sftx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int FW           = $clog2(BLOCK_FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [6:0]    cell_cnt,
  output logic [FW-1:0] frame_cnt,
  output logic          frame_last
);
  localparam logic [6:0]    LAST_CELL  = 7'(FRAME_CELLS - 1);
  localparam logic [FW-1:0] LAST_FRAME = FW'(BLOCK_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cell_cnt  <= '0;
      frame_cnt <= '0;
    end else begin
      cell_cnt <= cell_cnt + 7'd1;
      if (cell_cnt == LAST_CELL) begin
        frame_cnt <= (frame_cnt == LAST_FRAME) ? '0 : frame_cnt + FW'(1);
      end
    end
  end

  assign frame_last = en && (cell_cnt == LAST_CELL);
endmodule

// File: rtl/sftx_sample_hold.sv
module sftx_sample_hold #(
  parameter int AUD_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [AUD_W-1:0] in_left,
  input  logic [AUD_W-1:0] in_right,
  input  logic [1:0]       in_v,
  input  logic [1:0]       in_u,
  input  logic [1:0]       in_c,
  output logic [AUD_W-1:0] hold_left,
  output logic [AUD_W-1:0] hold_right,
  output logic [1:0]       hold_v,
  output logic [1:0]       hold_u,
  output logic [1:0]       hold_c
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_left  <= '0;
      hold_right <= '0;
      hold_v     <= '0;
      hold_u     <= '0;
      hold_c     <= '0;
    end else if (take) begin
      hold_left  <= in_left;
      hold_right <= in_right;
      hold_v     <= in_v;
      hold_u     <= in_u;
      hold_c     <= in_c;
    end
  end
endmodule

// File: rtl/sftx_word_build.sv
module sftx_word_build
  import sftx_pkg::*;
#(
  parameter int AUD_W = 24,
  parameter int FW    = 8
) (
  input  logic             second,
  input  logic [FW-1:0]    frame_cnt,
  input  logic             mono,
  input  logic             mono_dup,
  input  logic [AUD_W-1:0] hold_left,
  input  logic [AUD_W-1:0] hold_right,
  input  logic [1:0]       hold_v,
  input  logic [1:0]       hold_u,
  input  logic [1:0]       hold_c,
  output logic [31:0]      word,
  output pre_e             pre
);
  localparam int PAD = AUD_SLOTS - AUD_W;

  logic [AUD_SLOTS-1:0] left_al, right_al, aud;
  logic                 v, u, c;

  // Shorter samples sit at the MSB end of the 24 audio slots
  assign left_al  = AUD_SLOTS'(hold_left)  << PAD;
  assign right_al = AUD_SLOTS'(hold_right) << PAD;

  always_comb begin
    u = hold_u[second];
    c = hold_c[second];
    v = hold_v[second];
    if (!second) begin
      aud = left_al;
    end else if (!mono) begin
      aud = right_al;
    end else if (mono_dup) begin
      aud = left_al;
    end else begin
      aud = '0;
      v   = 1'b1;
    end
  end

  assign word = {^{c, u, v, aud}, c, u, v, aud, 4'b0000};

  always_comb begin
    if (second)                 pre = PRE_W;
    else if (frame_cnt == '0)   pre = PRE_B;
    else                        pre = PRE_M;
  end
endmodule

// File: rtl/sftx_bmc.sv
module sftx_bmc
  import sftx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [6:0]  cell_cnt,
  input  logic [31:0] word,
  input  pre_e        pre,
  output logic        line
);
  logic [5:0]  idx;
  logic [31:0] word_q;
  pre_e        pre_q;
  logic        pol_q;
  logic [7:0]  pat;
  logic        nxt;

  assign idx = cell_cnt[5:0];
  assign pat = pre_cells(pre_q);

  always_comb begin
    if (idx == 6'd0) begin
      nxt = ~line;
    end else if (idx < 6'(PRE_CELLS)) begin
      nxt = pat[3'd7 - idx[2:0]] ^ pol_q;
    end else if (!idx[0]) begin
      nxt = ~line;
    end else begin
      nxt = word_q[idx[5:1]] ? ~line : line;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      line   <= 1'b0;
      word_q <= '0;
      pre_q  <= PRE_M;
      pol_q  <= 1'b0;
    end else begin
      line <= nxt;
      if (idx == 6'd0) begin
        word_q <= word;
        pre_q  <= pre;
        pol_q  <= line;
      end
    end
  end
endmodule

// File: rtl/spdif_frame_tx.sv
module spdif_frame_tx
  import sftx_pkg::*;
#(
  parameter int AUD_W        = 24,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mono,
  input  logic             mono_dup,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [AUD_W-1:0] s_left,
  input  logic [AUD_W-1:0] s_right,
  input  logic [1:0]       s_vbit,
  input  logic [1:0]       s_ubit,
  input  logic [1:0]       s_cbit,
  output logic             tx_line
);
  localparam int FW = $clog2(BLOCK_FRAMES);

  logic [6:0]       cell_cnt;
  logic [FW-1:0]    frame_cnt;
  logic             frame_last;
  logic [AUD_W-1:0] hold_left, hold_right;
  logic [1:0]       hold_v, hold_u, hold_c;
  logic [31:0]      word;
  pre_e             pre;

  sftx_timing #(.BLOCK_FRAMES(BLOCK_FRAMES), .FW(FW)) timing_i (
    .clk(clk), .rst(rst), .en(en),
    .cell_cnt(cell_cnt), .frame_cnt(frame_cnt), .frame_last(frame_last)
  );

  assign s_ready = frame_last;

  sftx_sample_hold #(.AUD_W(AUD_W)) hold_i (
    .clk(clk), .rst(rst), .take(s_valid && frame_last),
    .in_left(s_left), .in_right(s_right),
    .in_v(s_vbit), .in_u(s_ubit), .in_c(s_cbit),
    .hold_left(hold_left), .hold_right(hold_right),
    .hold_v(hold_v), .hold_u(hold_u), .hold_c(hold_c)
  );

  sftx_word_build #(.AUD_W(AUD_W), .FW(FW)) build_i (
    .second(cell_cnt[6]), .frame_cnt(frame_cnt),
    .mono(mono), .mono_dup(mono_dup),
    .hold_left(hold_left), .hold_right(hold_right),
    .hold_v(hold_v), .hold_u(hold_u), .hold_c(hold_c),
    .word(word), .pre(pre)
  );

  sftx_bmc bmc_i (
    .clk(clk), .rst(rst), .en(en), .cell_cnt(cell_cnt),
    .word(word), .pre(pre), .line(tx_line)
  );
endmodule

// File: rtl/sftx_checker.sv
module sftx_checker #(
  parameter int BLOCK_FRAMES = 192,
  parameter int FW           = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          s_ready,
  input logic          tx_line,
  input logic [6:0]    cell_cnt,
  input logic [FW-1:0] frame_cnt
);
  localparam int FRAME_CELLS = 128;

  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (s_ready) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 8'd1;
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> !s_ready); // R1
  AST_READY_SPACING: assert property (@(posedge clk) disable iff (rst)
    (s_ready && seen) |-> (gap == 8'(FRAME_CELLS - 1))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |-> !s_ready); // R12
  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tx_line); // R12
  AST_SLOT_START_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && !$past(cell_cnt[0]) &&
     (($past(cell_cnt[5:0]) == 6'd0) || ($past(cell_cnt[5:0]) >= 6'd8)))
    |-> (tx_line != $past(tx_line))); // R7
  AST_BLOCK_RANGE: assert property (@(posedge clk) disable iff (rst)
    frame_cnt < FW'(BLOCK_FRAMES)); // R3
  AST_BLOCK_RESTART: assert property (@(posedge clk) disable iff (rst)
    !en |=> (frame_cnt == '0)); // R4
endmodule

bind spdif_frame_tx sftx_checker #(.BLOCK_FRAMES(BLOCK_FRAMES), .FW(FW)) chk_i (
  .clk(clk), .rst(rst), .en(en), .s_ready(s_ready), .tx_line(tx_line),
  .cell_cnt(cell_cnt), .frame_cnt(frame_cnt)
);

// File: tb/spdif_frame_tx_tb_top.sv
`timescale 1ns/100ps
module spdif_frame_tx_tb_top;
  localparam int AUD_W = 24;
  localparam int NF    = 194;

  logic clk = 1'b0;
  logic rst, en, mono, mono_dup, s_valid, s_ready, tx_line;
  logic [AUD_W-1:0] s_left, s_right;
  logic [1:0] s_vbit, s_ubit, s_cbit;

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spdif_frame_tx #(.AUD_W(AUD_W), .BLOCK_FRAMES(192)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mono(mono), .mono_dup(mono_dup),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .s_vbit(s_vbit), .s_ubit(s_ubit), .s_cbit(s_cbit), .tx_line(tx_line)
  );

  // scoreboard queues: expected subframe word, preamble code (0 B, 1 M, 2 W), tag
  logic [31:0] qw[$];
  int          qp[$];
  string       qt[$];

  logic [23:0] h_l = '0, h_r = '0;
  logic [1:0]  h_v = '0, h_u = '0, h_c = '0;

  logic        mon_on = 1'b0;
  logic        mlvl   = 1'b0;
  logic [63:0] rx     = '0;
  int          ncell  = 0;

  function automatic logic [31:0] mkw(input logic [23:0] a, input logic v,
                                      input logic u, input logic c);
    logic [31:0] w;
    w = '0;
    w[27:4] = a;
    w[28] = v;
    w[29] = u;
    w[30] = c;
    w[31] = ^w[30:4];
    return w;
  endfunction

  function automatic logic [63:0] enc(input logic lvl, input int p,
                                      input logic [31:0] w, output logic lvl_o);
    logic [63:0] cells;
    logic [7:0]  pat;
    logic        l;
    pat = (p == 0) ? 8'hE8 : (p == 2) ? 8'hE4 : 8'hE2;
    if (lvl) pat = ~pat;
    cells = '0;
    cells[63:56] = pat;
    l = pat[0];
    for (int s = 4; s < 32; s++) begin
      l = ~l;
      cells[63 - 2*s] = l;
      if (w[s]) l = ~l;
      cells[62 - 2*s] = l;
    end
    lvl_o = l;
    return cells;
  endfunction

  task automatic push_frame(input int g, input string tag);
    logic [31:0] w2;
    string t1;
    t1 = (g % 192 == 0) ? "R3" : tag;
    qw.push_back(mkw(h_l, h_v[0], h_u[0], h_c[0]));
    qp.push_back((g % 192 == 0) ? 0 : 1);
    qt.push_back(t1);
    if (!mono)         w2 = mkw(h_r, h_v[1], h_u[1], h_c[1]);
    else if (mono_dup) w2 = mkw(h_l, h_v[1], h_u[1], h_c[1]);
    else               w2 = mkw(24'h0, 1'b1, h_u[1], h_c[1]);
    qw.push_back(w2);
    qp.push_back(2);
    qt.push_back(tag);
  endtask

  task automatic chk(input logic ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor: collects 64 cells, pops the expected subframe and compares
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      rx = {rx[62:0], tx_line};
      ncell++;
      if (ncell == 64) begin
        logic [63:0] exp;
        logic        nl;
        ncell = 0;
        if (qw.size() == 0) begin
          chk(1'b0, "R1 scoreboard empty", rx, '0);
          mon_on = 1'b0;
        end else begin
          exp = enc(mlvl, qp[0], qw[0], nl);
          mlvl = nl;
          chk(rx === exp, {"R2/R5/R6/R7 ", qt[0]}, rx, exp);
          void'(qw.pop_front());
          void'(qp.pop_front());
          void'(qt.pop_front());
          if (qw.size() == 0) mon_on = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic wait_ready();
    do @(negedge clk); while (!s_ready);
  endtask

  task automatic run_frames(input int nframes);
    longint last;
    last = 0;
    for (int f = 0; f < nframes; f++) begin
      string tag;
      int k;
      wait_ready();
      if (f > 0) chk((cyc - last) == 128, "R1 ready spacing", 64'(cyc - last), 64'd128);
      last = cyc;
      if (f != nframes - 1) begin
        k = f % 6;
        s_valid = 1'b0;
        case (k)
          0: begin mono = 1'b0; s_valid = 1'b1; tag = "R8";
               s_left = 24'($urandom); s_right = 24'($urandom);
               s_vbit = 2'($urandom); s_ubit = 2'($urandom); s_cbit = 2'($urandom); end
          2: begin mono = 1'b1; mono_dup = 1'b1; s_valid = 1'b1; tag = "R9";
               s_left = 24'($urandom); s_right = 24'($urandom);
               s_vbit = 2'b00; s_ubit = 2'($urandom); s_cbit = 2'($urandom); end
          3: begin mono = 1'b1; mono_dup = 1'b0; s_valid = 1'b1; tag = "R10";
               s_left = 24'($urandom); s_right = 24'hABCDEF;
               s_vbit = 2'b00; s_ubit = 2'($urandom); s_cbit = 2'($urandom); end
          4: begin mono = 1'b0; s_valid = 1'b1; tag = "R6";
               s_left = 24'hFFFFFF; s_right = 24'h800001;
               s_vbit = 2'b11; s_ubit = 2'b11; s_cbit = 2'b11; end
          default: begin mono = 1'b0; tag = "R11"; end
        endcase
        if (s_valid) begin
          h_l = s_left; h_r = s_right; h_v = s_vbit; h_u = s_ubit; h_c = s_cbit;
        end
        push_frame(f + 1, tag);
      end
      @(negedge clk);
      s_valid = 1'b0;
    end
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; mono = 1'b0; mono_dup = 1'b0; s_valid = 1'b0;
    s_left = '0; s_right = '0; s_vbit = '0; s_ubit = '0; s_cbit = '0;
    repeat (4) @(negedge clk);
    chk(!tx_line && !s_ready, "R13 reset state", {62'd0, tx_line, s_ready}, 64'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tx_line && !s_ready, "R12 idle before enable", {62'd0, tx_line, s_ready}, 64'd0);

    // first frame sends the reset-cleared hold registers
    push_frame(0, "R13");
    mlvl = 1'b0;
    en = 1'b1;
    mon_on = 1'b1;
    run_frames(NF);
    wait (!mon_on);
    @(negedge clk);
    en = 1'b0;
    s_valid = 1'b1;
    s_left = 24'h123456;
    repeat (3) @(negedge clk);
    chk(!tx_line && !s_ready, "R12 idle after disable", {62'd0, tx_line, s_ready}, 64'd0);
    s_valid = 1'b0;

    // restart: block count must begin again at B; held pair repeats
    mono = 1'b0;
    push_frame(0, "R4");
    mlvl = 1'b0;
    en = 1'b1;
    mon_on = 1'b1;
    run_frames(3);
    wait (!mon_on);
    @(negedge clk);
    chk(qw.size() == 0, "R1 all expected subframes seen", 64'(qw.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule